// File: doc/BRIEF.md
# UART DMA Ready and Modem-Control Glue

This block is the per-channel status and modem-control logic that sits beside the FIFOs of a UART channel. It takes the receive and transmit FIFO occupancy, the DMA mode selection and the receive trigger level. From these it produces two active-low handshake outputs for a DMA engine: receive-ready and transmit-ready. The serialiser, the FIFOs and the register decode are outside this block. They provide the counts and control bits as plain inputs.

It also turns the modem-control bits into pin levels. One bit drives the active-low request-to-send output. A second bit does two jobs at once: it enables the interrupt output driver and it drives the user output pin low. The ring-indicator input is synchronised and watched for rising transitions, which latch a modem-status flag. A read of the modem status clears that flag. In loopback mode the serial transmit stream is routed internally to the receiver, and the transmit pin is held idle.

Top module: `uart_dma_mdm_glue`

## Requirements
- R1: With dma_mode=0, rxrdy_n is 0 one clock after rx_count is nonzero and 1 one clock after rx_count is 0.
- R2: With dma_mode=1, rxrdy_n is 0 one clock after rx_count is nonzero and at least rx_trig. Otherwise it is 1.
- R3: With dma_mode=0, txrdy_n is 0 one clock after tx_count is 0 and 1 otherwise.
- R4: With dma_mode=1, txrdy_n is 0 one clock after tx_count is below DEPTH, and 1 once tx_count equals DEPTH.
- R5: rts_n equals the inverse of mcr_rts one clock later. It has no connection to the serial paths.
- R6: One clock after mcr_out2 is sampled, irq_oe follows mcr_out2 and op2_o is its inverse. irq_o carries irq_src while irq_oe=1.
- R7: A 0-to-1 transition on ring_in sets ring_flag, which is visible on the third rising clock edge after the change. A steady ring_in never sets it.
- R8: msr_read=1 clears ring_flag on the next edge, unless a new ring edge is being detected in the same cycle, in which case the flag stays set.
- R9: With mcr_loop=1, tx_pin is 1, rx_ser follows tx_ser and rx_pin has no effect. With mcr_loop=0, tx_pin follows tx_ser and rx_ser follows rx_pin.
- R10: While rst=1, rxrdy_n, txrdy_n, rts_n, op2_o, tx_pin and rx_ser are 1, and irq_oe and ring_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| dma_mode | input | 1 | 0 selects single-transfer handshake, 1 selects block handshake |
| rx_count | input | CNT_W | Characters held in the receive FIFO |
| rx_trig | input | CNT_W | Programmed receive trigger level |
| tx_count | input | CNT_W | Characters held in the transmit FIFO |
| mcr_rts | input | 1 | Request-to-send control bit |
| mcr_out2 | input | 1 | Interrupt-enable / user-output control bit |
| mcr_loop | input | 1 | Local loopback enable |
| irq_src | input | 1 | Interrupt request from the channel core |
| ring_in | input | 1 | Asynchronous ring-indicator pin |
| msr_read | input | 1 | Pulse marking a modem-status read |
| tx_ser | input | 1 | Serial data from the transmitter |
| rx_pin | input | 1 | External serial receive pin |
| rxrdy_n | output | 1 | Active-low receive ready |
| txrdy_n | output | 1 | Active-low transmit ready |
| rts_n | output | 1 | Active-low request to send |
| op2_o | output | 1 | User output pin |
| irq_o | output | 1 | Interrupt data value |
| irq_oe | output | 1 | Interrupt output driver enable |
| ring_flag | output | 1 | Latched ring-edge status |
| tx_pin | output | 1 | External serial transmit pin |
| rx_ser | output | 1 | Serial data to the receiver |

## Verification
The bench builds the block with DEPTH=8, so CNT_W is 4. This puts a completely full transmit FIFO and every trigger level within easy reach of random counts. The trigger comparison is exercised below, at and above its threshold, and the counts at zero and at full are hit many times. The ring path is driven with directed edges so that the three-edge latency and the clash between a read and a new edge are both reached.

// File: rtl/uart_dma_mdm_glue.sv
module uart_dma_mdm_glue #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             mcr_rts,
  input  logic             mcr_out2,
  input  logic             mcr_loop,
  input  logic             irq_src,
  input  logic             ring_in,
  input  logic             msr_read,
  input  logic             tx_ser,
  input  logic             rx_pin,
  output logic             rxrdy_n,
  output logic             txrdy_n,
  output logic             rts_n,
  output logic             op2_o,
  output logic             irq_o,
  output logic             irq_oe,
  output logic             ring_flag,
  output logic             tx_pin,
  output logic             rx_ser
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic rx_has, rx_hit, tx_free, tx_empty;
  logic rx_go, tx_go;
  logic ri_s1, ri_s2, ri_d, ri_rise;
  logic out2_q, irq_q;

  assign rx_has   = rx_count != '0;
  assign rx_hit   = rx_has && (rx_count >= rx_trig);
  assign tx_empty = tx_count == '0;
  assign tx_free  = tx_count < FULL;
  assign rx_go    = dma_mode ? rx_hit  : rx_has;
  assign tx_go    = dma_mode ? tx_free : tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b1;
      rts_n   <= 1'b1;
      out2_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      rxrdy_n <= ~rx_go;
      txrdy_n <= ~tx_go;
      rts_n   <= ~mcr_rts;
      out2_q  <= mcr_out2;
      irq_q   <= irq_src;
    end
  end

  assign irq_oe = out2_q;
  assign op2_o  = ~out2_q;
  assign irq_o  = irq_q;

  assign ri_rise = ri_s2 & ~ri_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ri_s1     <= 1'b1;
      ri_s2     <= 1'b1;
      ri_d      <= 1'b1;
      ring_flag <= 1'b0;
    end else begin
      ri_s1 <= ring_in;
      ri_s2 <= ri_s1;
      ri_d  <= ri_s2;
      if (ri_rise)       ring_flag <= 1'b1;
      else if (msr_read) ring_flag <= 1'b0;
    end
  end

  assign tx_pin = rst | mcr_loop | tx_ser;
  assign rx_ser = rst | (mcr_loop ? tx_ser : rx_pin);

endmodule

// File: rtl/uart_dma_mdm_glue_chk.sv
module uart_dma_mdm_glue_chk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             dma_mode,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             mcr_rts,
  input logic             mcr_out2,
  input logic             mcr_loop,
  input logic             tx_ser,
  input logic             rxrdy_n,
  input logic             txrdy_n,
  input logic             rts_n,
  input logic             irq_oe,
  input logic             tx_pin,
  input logic             rx_ser
);

  assert_rx_empty_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> rxrdy_n);

  assert_tx_full_R4: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && tx_count == CNT_W'(DEPTH)) |=> txrdy_n);

  assert_rts_follow_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rts_n == !$past(mcr_rts)));

  assert_out2_oe_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_oe == $past(mcr_out2)));

  assert_loop_route_R9: assert property (@(posedge clk) disable iff (rst)
    mcr_loop |-> (tx_pin && rx_ser == tx_ser));

endmodule

bind uart_dma_mdm_glue uart_dma_mdm_glue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .dma_mode(dma_mode), .rx_count(rx_count),
  .tx_count(tx_count), .mcr_rts(mcr_rts), .mcr_out2(mcr_out2),
  .mcr_loop(mcr_loop), .tx_ser(tx_ser), .rxrdy_n(rxrdy_n),
  .txrdy_n(txrdy_n), .rts_n(rts_n), .irq_oe(irq_oe), .tx_pin(tx_pin),
  .rx_ser(rx_ser)
);

// File: tb/uart_dma_mdm_glue_tb.sv
`timescale 1ns/1ps
module uart_dma_mdm_glue_tb;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_mode = 0, mcr_rts = 0, mcr_out2 = 0, mcr_loop = 0;
  logic irq_src = 0, ring_in = 1, msr_read = 0, tx_ser = 1, rx_pin = 1;
  logic [CNT_W-1:0] rx_count = '0, rx_trig = '0, tx_count = '0;
  logic rxrdy_n, txrdy_n, rts_n, op2_o, irq_o, irq_oe, ring_flag, tx_pin, rx_ser;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_dma_mdm_glue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .dma_mode(dma_mode), .rx_count(rx_count),
    .rx_trig(rx_trig), .tx_count(tx_count), .mcr_rts(mcr_rts),
    .mcr_out2(mcr_out2), .mcr_loop(mcr_loop), .irq_src(irq_src),
    .ring_in(ring_in), .msr_read(msr_read), .tx_ser(tx_ser), .rx_pin(rx_pin),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .rts_n(rts_n), .op2_o(op2_o),
    .irq_o(irq_o), .irq_oe(irq_oe), .ring_flag(ring_flag), .tx_pin(tx_pin),
    .rx_ser(rx_ser)
  );

  function automatic logic exp_rxrdy(logic m, int cnt, int trg);
    if (cnt == 0) return 1'b1;
    if (m && cnt < trg) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_txrdy(logic m, int cnt);
    if (m) return (cnt >= DEPTH) ? 1'b1 : 1'b0;
    return (cnt == 0) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R10 rxrdy", rxrdy_n, 1); chk("R10 txrdy", txrdy_n, 1);
    chk("R10 rts", rts_n, 1);     chk("R10 op2", op2_o, 1);
    chk("R10 oe", irq_oe, 0);     chk("R10 ring", ring_flag, 0);
    tx_ser = 0; rx_pin = 0; #1;
    chk("R10 txpin", tx_pin, 1);  chk("R10 rxser", rx_ser, 1);
    rst = 0;

    // directed trigger and fullness corners
    @(negedge clk); dma_mode = 1; rx_trig = 4; rx_count = 3; tx_count = CNT_W'(DEPTH);
    @(negedge clk); chk("R2 below trig", rxrdy_n, 1); chk("R4 full", txrdy_n, 1);
    rx_count = 4; tx_count = CNT_W'(DEPTH - 1);
    @(negedge clk); chk("R2 at trig", rxrdy_n, 0); chk("R4 one free", txrdy_n, 0);
    dma_mode = 0; rx_count = 1; tx_count = 1;
    @(negedge clk); chk("R1 one char", rxrdy_n, 0); chk("R3 not empty", txrdy_n, 1);
    tx_count = 0;
    @(negedge clk); chk("R3 empty", txrdy_n, 0);

    for (int i = 0; i < 400; i++) begin
      logic m, rts, o2, irq, lp, ts, rp;
      int rc, rt, tc;
      m = 1'($urandom); rts = 1'($urandom); o2 = 1'($urandom); irq = 1'($urandom);
      lp = 1'($urandom); ts = 1'($urandom); rp = 1'($urandom);
      rc = $urandom_range(0, DEPTH); rt = $urandom_range(1, DEPTH); tc = $urandom_range(0, DEPTH);
      dma_mode = m; mcr_rts = rts; mcr_out2 = o2; irq_src = irq; mcr_loop = lp;
      tx_ser = ts; rx_pin = rp;
      rx_count = CNT_W'(rc); rx_trig = CNT_W'(rt); tx_count = CNT_W'(tc);
      #1;
      chk("R9 txpin", tx_pin, lp ? 1'b1 : ts);
      chk("R9 rxser", rx_ser, lp ? ts : rp);
      @(negedge clk);
      chk(m ? "R2 rxrdy" : "R1 rxrdy", rxrdy_n, exp_rxrdy(m, rc, rt));
      chk(m ? "R4 txrdy" : "R3 txrdy", txrdy_n, exp_txrdy(m, tc));
      chk("R5 rts", rts_n, ~rts);
      chk("R6 oe", irq_oe, o2);
      chk("R6 op2", op2_o, ~o2);
      if (o2) chk("R6 irq", irq_o, irq);
      chk("R7 steady ring", ring_flag, 0);
    end

    // ring edge latency
    ring_in = 0;
    repeat (4) @(negedge clk);
    chk("R7 falling no flag", ring_flag, 0);
    ring_in = 1;
    @(negedge clk); chk("R7 edge+1", ring_flag, 0);
    @(negedge clk); chk("R7 edge+2", ring_flag, 0);
    @(negedge clk); chk("R7 edge+3", ring_flag, 1);
    repeat (3) @(negedge clk); chk("R7 held", ring_flag, 1);
    msr_read = 1;
    @(negedge clk); msr_read = 0; chk("R8 cleared", ring_flag, 0);
    // read colliding with a new edge
    ring_in = 0; repeat (4) @(negedge clk);
    ring_in = 1; repeat (2) @(negedge clk);
    msr_read = 1;
    @(negedge clk); msr_read = 0; chk("R8 set wins", ring_flag, 1);
    msr_read = 1;
    @(negedge clk); msr_read = 0; chk("R8 later read", ring_flag, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule